// File: doc/BRIEF.md
# CPU Memory Router with Mirrored Display Writes

This block sits behind an already decoded 8-bit, 20-bit-address CPU memory bus and steers each access to one of three stores: a boot ROM that lives on the chip, an external 1 MB asynchronous SRAM, and a dual-port video RAM that the block contains. The top 64 KB of the address space is served by the ROM. The lower 640 KB, together with a video window, is ordinary SRAM. Any write that lands inside the video window is also copied into the video RAM.

CPU reads never touch the video RAM. Inside the video window they are answered by the SRAM, which holds the same bytes because every write was mirrored. As a result the video RAM's second port is reserved for a display scan-out engine, which can read at any time without arbitration and without stalling the CPU. Addresses between the end of conventional memory and the ROM that fall outside the video window read back as all ones. Writes to them still reach the SRAM.

Read data is registered. The source chosen on the first cycle of a read strobe is kept until the strobe drops. Each write strobe produces exactly one cycle of write enable, however long the strobe is held.

Top module: `mem_router`

## Requirements
- R1: A read whose address is F0000h or above is answered from the ROM: `rom_en` is high, `sram_oe` is low, and `cpu_rdata` equals `rom_rdata` for `rom_addr` = `cpu_addr[15:0]`.
- R2: A read below A0000h (640 KB) is answered from the SRAM: `sram_oe` is high, `rom_en` is low, and `cpu_rdata` equals `sram_rdata` for `sram_addr` = `cpu_addr`.
- R3: A read inside the video window (default B8000h to B8FFFh) is answered from the SRAM only, never from the video RAM.
- R4: A read at an address from A0000h up to EFFFFh that is outside the video window returns FFh, and both `sram_oe` and `rom_en` stay low.
- R5: `cpu_rdata` is registered and holds the result at the first rising edge at which `cpu_rd` is high. The source picked on the first cycle of the strobe is kept until `cpu_rd` falls, even if `cpu_addr` changes in the meantime.
- R6: A write inside the video window raises `sram_we` and writes the video RAM at offset `cpu_addr` − B8000h in the same cycle. The byte can then be read on the display port.
- R7: A write at F0000h or above raises no `sram_we` and changes neither the video RAM nor later ROM reads.
- R8: A write outside both the ROM range and the video window raises `sram_we`, with `sram_addr` = `cpu_addr` and `sram_wdata` = `cpu_wdata`, and leaves the video RAM unchanged.
- R9: `sram_we` is high for exactly one clock per write strobe: in the first cycle that `cpu_wr` is high, and never while the strobe is held.
- R10: `disp_rdata` returns the video RAM byte at `disp_addr` one clock later. It is independent of CPU traffic. When a CPU write hits the same offset in the same cycle, the display port returns the old byte.
- R11: After reset, `cpu_rdata` is 00h and, with both strobes low, `sram_we`, `sram_oe` and `rom_en` are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cpu_addr | input | 20 | CPU byte address |
| cpu_wdata | input | 8 | CPU write data |
| cpu_rd | input | 1 | Memory read strobe |
| cpu_wr | input | 1 | Memory write strobe |
| cpu_rdata | output | 8 | Registered read data to the CPU |
| rom_en | output | 1 | ROM read enable |
| rom_addr | output | 16 | ROM byte address |
| rom_rdata | input | 8 | ROM data |
| sram_addr | output | 20 | SRAM address |
| sram_wdata | output | 8 | SRAM write data |
| sram_rdata | input | 8 | SRAM read data |
| sram_oe | output | 1 | SRAM output enable |
| sram_we | output | 1 | SRAM write enable, one clock per write |
| disp_addr | input | 12 | Display-port video RAM offset |
| disp_rdata | output | 8 | Display-port read data, one clock later |

## Verification
The display port and a CPU write that is mirrored into the video RAM can fall on the same clock, and so can the display port and a CPU read in the video window. The bench provokes both. It drives `disp_addr` in the same cycle as a window write, once at the offset being written and once at a different offset. It also issues a window read while the display port is reading the same offset. In each case it checks that the display port returns the old byte, or the untouched neighbour, and that the CPU read returns the SRAM's value and not the video RAM's.

// File: rtl/mr_pkg.sv
package mr_pkg;
  typedef enum logic [1:0] {
    SRC_SRAM = 2'd0,
    SRC_ROM  = 2'd1,
    SRC_OPEN = 2'd2
  } rd_src_e;
endpackage

// File: rtl/mr_rst_sync.sv
module mr_rst_sync (
  input  logic clk,
  input  logic rst_n,
  output logic rst_sync_n
);
  logic meta_q;
  logic hold_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      meta_q <= 1'b0;
      hold_q <= 1'b0;
    end else begin
      meta_q <= 1'b1;
      hold_q <= meta_q;
    end
  end

  assign rst_sync_n = hold_q;
endmodule

// File: rtl/mr_decode.sv
module mr_decode
  import mr_pkg::*;
#(
  parameter int                 ADDR_W    = 20,
  parameter int                 VID_AW    = 12,
  parameter logic [ADDR_W-1:0]  CONV_TOP  = 20'hA0000,
  parameter logic [ADDR_W-1:0]  VID_BASE  = 20'hB8000,
  parameter logic [ADDR_W-1:0]  BIOS_BASE = 20'hF0000
) (
  input  logic [ADDR_W-1:0] addr,
  output rd_src_e           src,
  output logic              in_bios,
  output logic              in_vid,
  output logic [VID_AW-1:0] vid_off
);
  localparam logic [ADDR_W:0] VID_END = {1'b0, VID_BASE} + (ADDR_W+1)'(1 << VID_AW);

  logic [ADDR_W-1:0] off_full;

  always_comb begin
    in_bios  = (addr >= BIOS_BASE);
    in_vid   = (addr >= VID_BASE) && ({1'b0, addr} < VID_END);
    off_full = addr - VID_BASE;
    vid_off  = off_full[VID_AW-1:0];
    if (in_bios)
      src = SRC_ROM;
    else if ((addr < CONV_TOP) || in_vid)
      src = SRC_SRAM;
    else
      src = SRC_OPEN;
  end
endmodule

// File: rtl/mr_rdpath.sv
module mr_rdpath
  import mr_pkg::*;
#(
  parameter int DATA_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cpu_rd,
  input  rd_src_e           src_dec,
  input  logic [DATA_W-1:0] rom_rdata,
  input  logic [DATA_W-1:0] sram_rdata,
  output logic [DATA_W-1:0] cpu_rdata,
  output logic              sram_oe,
  output logic              rom_en
);
  logic              rd_q;
  logic              rd_start;
  rd_src_e           src_q, src_eff;
  logic [DATA_W-1:0] mux_data, rdata_q, rdata_nxt;

  always_comb begin
    rd_start = cpu_rd & ~rd_q;
    src_eff  = rd_start ? src_dec : src_q;
    case (src_eff)
      SRC_ROM:  mux_data = rom_rdata;
      SRC_SRAM: mux_data = sram_rdata;
      default:  mux_data = '1;
    endcase
    rdata_nxt = cpu_rd ? mux_data : rdata_q;
    sram_oe   = cpu_rd && (src_eff == SRC_SRAM);
    rom_en    = cpu_rd && (src_eff == SRC_ROM);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rd_q    <= 1'b0;
      src_q   <= SRC_OPEN;
      rdata_q <= '0;
    end else begin
      rd_q <= cpu_rd;
      if (rd_start) src_q <= src_eff;
      rdata_q <= rdata_nxt;
    end
  end

  assign cpu_rdata = rdata_q;

  AST_SRC_HELD: assert property (@(posedge clk) disable iff (!rst_n)
    cpu_rd && $past(cpu_rd) |-> $stable(src_eff)); // R5
  AST_OPEN_ALL_ONES: assert property (@(posedge clk) disable iff (!rst_n)
    cpu_rd && (src_eff == SRC_OPEN) |=> (cpu_rdata == '1)); // R4
  AST_ONE_SOURCE: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({sram_oe, rom_en})); // R3
endmodule

// File: rtl/mr_wrpath.sv
module mr_wrpath (
  input  logic clk,
  input  logic rst_n,
  input  logic cpu_wr,
  input  logic in_bios,
  input  logic in_vid,
  output logic sram_we,
  output logic vram_we
);
  logic wr_q;
  logic wr_start;

  always_comb begin
    wr_start = cpu_wr & ~wr_q;
    sram_we  = wr_start & ~in_bios;
    vram_we  = wr_start & in_vid;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) wr_q <= 1'b0;
    else        wr_q <= cpu_wr;
  end

  AST_WE_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
    sram_we |=> !sram_we); // R9
  AST_HELD_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
    cpu_wr && $past(cpu_wr) |-> !sram_we && !vram_we); // R9
endmodule

// File: rtl/mr_vram.sv
module mr_vram #(
  parameter int AW     = 12,
  parameter int DATA_W = 8
) (
  input  logic              clk,
  input  logic              wr_en,
  input  logic [AW-1:0]     wr_addr,
  input  logic [DATA_W-1:0] wr_data,
  input  logic [AW-1:0]     rd_addr,
  output logic [DATA_W-1:0] rd_data
);
  localparam int DEPTH = 1 << AW;

  logic [DATA_W-1:0] mem [DEPTH];
  logic [DATA_W-1:0] rd_q;

  always_ff @(posedge clk) begin
    if (wr_en) mem[wr_addr] <= wr_data;
    rd_q <= mem[rd_addr];
  end

  assign rd_data = rd_q;
endmodule

// File: rtl/mem_router.sv
module mem_router
  import mr_pkg::*;
#(
  parameter int                ADDR_W    = 20,
  parameter int                DATA_W    = 8,
  parameter int                VID_AW    = 12,
  parameter logic [ADDR_W-1:0] CONV_TOP  = 20'hA0000,
  parameter logic [ADDR_W-1:0] VID_BASE  = 20'hB8000,
  parameter logic [ADDR_W-1:0] BIOS_BASE = 20'hF0000,
  localparam int               BIOS_BYTES = (1 << ADDR_W) - int'(BIOS_BASE),
  localparam int               ROM_AW     = $clog2(BIOS_BYTES)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [ADDR_W-1:0] cpu_addr,
  input  logic [DATA_W-1:0] cpu_wdata,
  input  logic              cpu_rd,
  input  logic              cpu_wr,
  output logic [DATA_W-1:0] cpu_rdata,
  output logic              rom_en,
  output logic [ROM_AW-1:0] rom_addr,
  input  logic [DATA_W-1:0] rom_rdata,
  output logic [ADDR_W-1:0] sram_addr,
  output logic [DATA_W-1:0] sram_wdata,
  input  logic [DATA_W-1:0] sram_rdata,
  output logic              sram_oe,
  output logic              sram_we,
  input  logic [VID_AW-1:0] disp_addr,
  output logic [DATA_W-1:0] disp_rdata
);
  localparam logic [ADDR_W:0] VID_END = {1'b0, VID_BASE} + (ADDR_W+1)'(1 << VID_AW);

  logic              rst_int_n;
  rd_src_e           src_dec;
  logic              in_bios, in_vid, vram_we;
  logic [VID_AW-1:0] vid_off;

  mr_rst_sync u_rst (
    .clk        (clk),
    .rst_n      (rst_n),
    .rst_sync_n (rst_int_n)
  );

  mr_decode #(
    .ADDR_W(ADDR_W), .VID_AW(VID_AW), .CONV_TOP(CONV_TOP),
    .VID_BASE(VID_BASE), .BIOS_BASE(BIOS_BASE)
  ) u_dec (
    .addr    (cpu_addr),
    .src     (src_dec),
    .in_bios (in_bios),
    .in_vid  (in_vid),
    .vid_off (vid_off)
  );

  mr_rdpath #(.DATA_W(DATA_W)) u_rd (
    .clk        (clk),
    .rst_n      (rst_int_n),
    .cpu_rd     (cpu_rd),
    .src_dec    (src_dec),
    .rom_rdata  (rom_rdata),
    .sram_rdata (sram_rdata),
    .cpu_rdata  (cpu_rdata),
    .sram_oe    (sram_oe),
    .rom_en     (rom_en)
  );

  mr_wrpath u_wr (
    .clk     (clk),
    .rst_n   (rst_int_n),
    .cpu_wr  (cpu_wr),
    .in_bios (in_bios),
    .in_vid  (in_vid),
    .sram_we (sram_we),
    .vram_we (vram_we)
  );

  mr_vram #(.AW(VID_AW), .DATA_W(DATA_W)) u_vram (
    .clk     (clk),
    .wr_en   (vram_we),
    .wr_addr (vid_off),
    .wr_data (cpu_wdata),
    .rd_addr (disp_addr),
    .rd_data (disp_rdata)
  );

  assign rom_addr   = cpu_addr[ROM_AW-1:0];
  assign sram_addr  = cpu_addr;
  assign sram_wdata = cpu_wdata;

  AST_BIOS_WR_BLOCKED: assert property (@(posedge clk) disable iff (!rst_int_n)
    cpu_wr && (cpu_addr >= BIOS_BASE) |-> !sram_we); // R7
  AST_VID_MIRROR: assert property (@(posedge clk) disable iff (!rst_int_n)
    $rose(cpu_wr) && (cpu_addr >= VID_BASE) && ({1'b0, cpu_addr} < VID_END) |-> sram_we); // R6
  AST_BIOS_FROM_ROM: assert property (@(posedge clk) disable iff (!rst_int_n)
    $rose(cpu_rd) && (cpu_addr >= BIOS_BASE) |-> rom_en && !sram_oe); // R1
  AST_VID_FROM_SRAM: assert property (@(posedge clk) disable iff (!rst_int_n)
    $rose(cpu_rd) && (cpu_addr >= VID_BASE) && ({1'b0, cpu_addr} < VID_END) |-> sram_oe); // R3
endmodule

// File: tb/tb_mem_router.sv
module tb_mem_router;
  logic        clk;
  logic        rst_n;
  logic [19:0] cpu_addr;
  logic [7:0]  cpu_wdata;
  logic        cpu_rd, cpu_wr;
  logic [7:0]  cpu_rdata;
  logic        rom_en;
  logic [15:0] rom_addr;
  logic [7:0]  rom_rdata;
  logic [19:0] sram_addr;
  logic [7:0]  sram_wdata, sram_rdata;
  logic        sram_oe, sram_we;
  logic [11:0] disp_addr;
  logic [7:0]  disp_rdata;

  int n_chk  = 0;
  int n_fail = 0;
  bit done   = 0;

  mem_router dut (
    .clk(clk), .rst_n(rst_n), .cpu_addr(cpu_addr), .cpu_wdata(cpu_wdata),
    .cpu_rd(cpu_rd), .cpu_wr(cpu_wr), .cpu_rdata(cpu_rdata), .rom_en(rom_en),
    .rom_addr(rom_addr), .rom_rdata(rom_rdata), .sram_addr(sram_addr),
    .sram_wdata(sram_wdata), .sram_rdata(sram_rdata), .sram_oe(sram_oe),
    .sram_we(sram_we), .disp_addr(disp_addr), .disp_rdata(disp_rdata)
  );

  initial clk = 1'b0;
  always #10 clk = ~clk;

  function automatic logic [7:0] rom_fn(input logic [15:0] a);
    return ~a[7:0] ^ a[15:8];
  endfunction
  function automatic logic [7:0] sram_fn(input logic [19:0] a);
    return a[7:0] ^ a[15:8] ^ {4'h0, a[19:16]};
  endfunction

  assign rom_rdata  = rom_fn(rom_addr);
  assign sram_rdata = sram_fn(sram_addr);

  task automatic chk(input string req, input int act, input int exp);
    n_chk++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  task automatic do_read(input string req, input logic [19:0] a,
                         input int exp_data, input bit exp_oe, input bit exp_rom);
    @(negedge clk);
    cpu_addr = a; cpu_rd = 1'b1;
    #1;
    chk(req, int'(sram_oe), int'(exp_oe));
    chk(req, int'(rom_en), int'(exp_rom));
    @(negedge clk);
    chk(req, int'(cpu_rdata), exp_data);
    cpu_rd = 1'b0;
  endtask

  task automatic do_write(input string req, input logic [19:0] a,
                          input logic [7:0] d, input bit exp_we);
    @(negedge clk);
    cpu_addr = a; cpu_wdata = d; cpu_wr = 1'b1;
    #1;
    chk(req, int'(sram_we), int'(exp_we));
    if (exp_we) begin
      chk(req, int'(sram_addr), int'(a));
      chk(req, int'(sram_wdata), int'(d));
    end
    @(negedge clk);
    cpu_wr = 1'b0;
  endtask

  task automatic disp_read(input string req, input logic [11:0] off, input int exp);
    @(negedge clk);
    disp_addr = off;
    @(negedge clk);
    chk(req, int'(disp_rdata), exp);
  endtask

  task automatic t_reset;
    #1;
    chk("R11", int'(cpu_rdata), 0);
    chk("R11", int'(sram_we), 0);
    chk("R11", int'(sram_oe), 0);
    chk("R11", int'(rom_en), 0);
  endtask

  task automatic t_reads;
    do_read("R1", 20'hF0012, int'(rom_fn(16'h0012)), 1'b0, 1'b1);
    do_read("R1", 20'hFFFFF, int'(rom_fn(16'hFFFF)), 1'b0, 1'b1);
    do_read("R2", 20'h01234, int'(sram_fn(20'h01234)), 1'b1, 1'b0);
    do_read("R2", 20'h9FFFF, int'(sram_fn(20'h9FFFF)), 1'b1, 1'b0);
    do_read("R4", 20'hA0000, 8'hFF, 1'b0, 1'b0);
    do_read("R4", 20'hB7FFF, 8'hFF, 1'b0, 1'b0);
    do_read("R4", 20'hB9000, 8'hFF, 1'b0, 1'b0);
    do_read("R4", 20'hEFFFF, 8'hFF, 1'b0, 1'b0);
  endtask

  task automatic t_hold;
    @(negedge clk);
    cpu_addr = 20'hF0010; cpu_rd = 1'b1;
    @(negedge clk);
    chk("R5", int'(cpu_rdata), int'(rom_fn(16'h0010)));
    cpu_addr = 20'h00034;
    #1;
    chk("R5", int'(rom_en), 1);
    chk("R5", int'(sram_oe), 0);
    @(negedge clk);
    chk("R5", int'(cpu_rdata), int'(rom_fn(16'h0034)));
    cpu_rd = 1'b0;
    do_read("R5", 20'h00034, int'(sram_fn(20'h00034)), 1'b1, 1'b0);
  endtask

  task automatic t_vid_write;
    do_write("R6", 20'hB8000, 8'h5A, 1'b1);
    do_write("R6", 20'hB8FFF, 8'hC3, 1'b1);
    disp_read("R6", 12'h000, 8'h5A);
    disp_read("R6", 12'hFFF, 8'hC3);
    do_read("R3", 20'hB8000, int'(sram_fn(20'hB8000)), 1'b1, 1'b0);
  endtask

  task automatic t_bios_write;
    do_write("R7", 20'hF8000, 8'hEE, 1'b0);
    do_write("R7", 20'hF0FFF, 8'hEE, 1'b0);
    disp_read("R7", 12'h000, 8'h5A);
    disp_read("R7", 12'hFFF, 8'hC3);
    do_read("R7", 20'hF8000, int'(rom_fn(16'h8000)), 1'b0, 1'b1);
  endtask

  task automatic t_plain_write;
    do_write("R8", 20'h00000, 8'h11, 1'b1);
    do_write("R8", 20'hB7FFF, 8'h22, 1'b1);
    do_write("R8", 20'hB9000, 8'h33, 1'b1);
    disp_read("R8", 12'h000, 8'h5A);
    disp_read("R8", 12'hFFF, 8'hC3);
  endtask

  task automatic t_held_write;
    int pulses = 0;
    @(negedge clk);
    cpu_addr = 20'h04567; cpu_wdata = 8'h9C; cpu_wr = 1'b1;
    for (int i = 0; i < 4; i++) begin
      #1;
      if (sram_we) pulses++;
      @(negedge clk);
    end
    cpu_wr = 1'b0;
    chk("R9", pulses, 1);
    do_write("R9", 20'h04567, 8'h9D, 1'b1);
  endtask

  task automatic t_concurrent;
    do_write("R10", 20'hB8020, 8'h11, 1'b1);
    do_write("R10", 20'hB8021, 8'h99, 1'b1);
    @(negedge clk);
    cpu_addr = 20'hB8020; cpu_wdata = 8'h3C; cpu_wr = 1'b1; disp_addr = 12'h020;
    @(negedge clk);
    cpu_wr = 1'b0;
    chk("R10", int'(disp_rdata), 8'h11);
    @(negedge clk);
    chk("R10", int'(disp_rdata), 8'h3C);
    cpu_addr = 20'hB8030; cpu_wdata = 8'h77; cpu_wr = 1'b1; disp_addr = 12'h021;
    @(negedge clk);
    cpu_wr = 1'b0;
    chk("R10", int'(disp_rdata), 8'h99);
    disp_addr = 12'h020;
    cpu_addr = 20'hB8020; cpu_rd = 1'b1;
    @(negedge clk);
    chk("R3", int'(cpu_rdata), int'(sram_fn(20'hB8020)));
    chk("R10", int'(disp_rdata), 8'h3C);
    cpu_rd = 1'b0;
    disp_read("R10", 12'h030, 8'h77);
  endtask

  initial begin
    rst_n = 1'b0; cpu_addr = '0; cpu_wdata = '0; cpu_rd = 1'b0; cpu_wr = 1'b0;
    disp_addr = '0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    t_reset();
    t_reads();
    t_hold();
    t_vid_write();
    t_bios_write();
    t_plain_write();
    t_held_write();
    t_concurrent();
    repeat (2) @(negedge clk);
    done = 1'b1;
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      n_chk++;
      n_fail++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
      $finish;
    end
  end
endmodule